// File: doc/BRIEF.md
# Write-Through Snooping Data Cache Controller

This block is a direct-mapped, write-through data cache for a single processor that shares a snooping bus with other agents. Each line keeps one of two coherence states, Invalid or Valid. A processor load that hits a Valid line is answered at once without bus traffic. A load that misses asks for the whole line on the bus and waits until a line-fill response whose line address matches the pending request appears on the snoop input. The line is then installed as Valid and the requested word is returned.

Every processor store is sent on the bus as a one-word write, whether it hits or misses. A store hit also updates the local copy, and the line stays Valid. A store miss does not allocate a line. The controller watches every transaction on the snoop input. A write carrying another agent's requester ID whose line address matches a Valid line invalidates that whole line. Transactions that carry the controller's own ID are ignored, as are snooped reads and writes to lines that are not held. The bus arbiter and the memory controller are outside the block.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `bus_req` and `cpu_ready` are low, and the first load to any address misses. A reset applied later also drops every line that was held before it.
- R2: A load that hits a Valid line raises `cpu_ready` in the same cycle as the request, with the word on `cpu_rdata`. `bus_req` is not raised for that load.
- R3: A load miss raises `bus_req` with `bus_cmd` = 0 (read). `bus_addr` carries the line address with the word-offset bits at zero, and `bus_id` carries the controller's own ID.
- R4: A snoop transaction with `snp_cmd` = 2 (fill) whose `snp_laddr` equals the pending miss's line address is captured. The line becomes Valid, `cpu_ready` rises in that same cycle with the requested word, and later loads to the line hit.
- R5: Every store raises `bus_req` with `bus_cmd` = 1 (write), the full word address and the store data. `cpu_ready` rises in the cycle `bus_gnt` is high.
- R6: A store that hits writes the new word into the local line, and the line stays Valid. A store that misses leaves every line's state and contents unchanged.
- R7: A snoop transaction with `snp_cmd` = 1 (write), an `snp_id` different from the own ID, and a line address that matches a Valid line invalidates that line. This holds whichever word of the line was written.
- R8: A snooped write that carries the own ID is ignored. So are snooped reads (`snp_cmd` = 0) and snooped writes to an index whose stored tag differs.
- R9: While a bus request waits for `bus_gnt`, `cpu_ready` stays low, and `bus_req`, `bus_cmd`, `bus_addr` and `bus_wdata` hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Bus grant; the transaction is issued in a cycle where request and grant are both high |
| bus_cmd | output | 2 | 0 = read line, 1 = write word |
| bus_addr | output | ADDR_W | Word address (line-aligned for reads) |
| bus_wdata | output | DATA_W | Store data for writes |
| bus_id | output | ID_W | Own requester ID |
| snp_valid | input | 1 | A bus transaction is visible on the snoop port |
| snp_cmd | input | 2 | 0 = read, 1 = write, 2 = line fill |
| snp_laddr | input | ADDR_W-log2(WORDS) | Line address of the snooped transaction |
| snp_id | input | ID_W | Requester ID of the snooped transaction |
| snp_line | input | WORDS*DATA_W | Fill data; word w sits at bits w*DATA_W |

## Verification
The bench builds the block with a 4-line cache, 2-word lines, 16-bit data, 8-bit word addresses, a 2-bit ID field and an own ID of 1. A 32-word random address window therefore maps many tags onto each index. This produces frequent conflict evictions, store misses next to cached lines, and snooped writes that land on the other word of a held line. Grant and fill delays are drawn at random, and one directed load waits six cycles for its grant to exercise the stall path.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
   localparam logic [1:0] CMD_RD   = 2'd0;
   localparam logic [1:0] CMD_WR   = 2'd1;
   localparam logic [1:0] CMD_FILL = 2'd2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARB  = 2'd1,
      ST_FILL = 2'd2
   } ctrl_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store
   import wtc_pkg::*;
#(
   parameter int LINES = 16,
   parameter int IDX_W = 4,
   parameter int TAG_W = 8,
   parameter int ID_W  = 3,
   parameter int MY_ID = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [ID_W-1:0]  snp_id,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [TAG_W-1:0] fill_tag
);
   logic [LINES-1:0] valid_vec;
   logic [TAG_W-1:0] tag_arr [LINES];
   logic             kill;

   assign kill = snp_valid && (snp_cmd == CMD_WR) && (snp_id != ID_W'(MY_ID)) &&
                 valid_vec[snp_idx] && (tag_arr[snp_idx] == snp_tag);

   assign lk_hit = valid_vec[lk_idx] && (tag_arr[lk_idx] == lk_tag);

   for (genvar i = 0; i < LINES; i++) begin : g_line
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
         end else if (fill_en && fill_idx == IDX_W'(i)) begin
            v_q <= 1'b1;
            t_q <= fill_tag;
         end else if (kill && snp_idx == IDX_W'(i)) begin
            v_q <= 1'b0;
         end
      end
      assign valid_vec[i] = v_q;
      assign tag_arr[i]   = t_q;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (valid_vec == '0));

   assert_fill_install_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (valid_vec[$past(fill_idx)] && tag_arr[$past(fill_idx)] == $past(fill_tag)));

   assert_snoop_kill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !fill_en) |=> !valid_vec[$past(snp_idx)]);

   assert_own_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_id == ID_W'(MY_ID) && !fill_en) |=> (valid_vec == $past(valid_vec)));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
   parameter int LINES  = 16,
   parameter int IDX_W  = 4,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line
);
   logic [LINE_W-1:0] mem [LINES];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_line;
   end

   assign rd_line = mem[rd_idx];
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int WORDS  = 4,
   parameter int OFF_W  = 2,
   parameter int LINE_W = 128
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [DATA_W-1:0]       cpu_wdata,
   output logic                    cpu_ready,
   output logic [DATA_W-1:0]       cpu_rdata,
   output logic                    bus_req,
   input  logic                    bus_gnt,
   output logic [1:0]              bus_cmd,
   output logic [ADDR_W-1:0]       bus_addr,
   output logic [DATA_W-1:0]       bus_wdata,
   input  logic                    snp_valid,
   input  logic [1:0]              snp_cmd,
   input  logic [ADDR_W-OFF_W-1:0] snp_laddr,
   input  logic [LINE_W-1:0]       snp_line,
   output logic [ADDR_W-OFF_W-1:0] lk_laddr,
   input  logic                    lk_hit,
   input  logic [LINE_W-1:0]       rd_line,
   output logic                    fill_en,
   output logic                    wr_en,
   output logic [LINE_W-1:0]       wr_line
);
   ctrl_state_e       state_q;
   logic [ADDR_W-1:0] hold_addr_q;
   logic [DATA_W-1:0] hold_data_q;
   logic              hold_we_q;

   logic [ADDR_W-1:0] lk_addr;
   logic [OFF_W-1:0]  lk_off;
   logic              resp_hit, rd_hit, st_done;
   logic [DATA_W-1:0] src_words [WORDS];

   assign lk_addr  = (state_q == ST_IDLE) ? cpu_addr : hold_addr_q;
   assign lk_laddr = lk_addr[ADDR_W-1:OFF_W];
   assign lk_off   = lk_addr[OFF_W-1:0];

   assign resp_hit = (state_q == ST_FILL) && snp_valid && (snp_cmd == CMD_FILL) &&
                     (snp_laddr == hold_addr_q[ADDR_W-1:OFF_W]);
   assign rd_hit   = (state_q == ST_IDLE) && cpu_req && !cpu_we && lk_hit;
   assign st_done  = (state_q == ST_ARB) && bus_gnt && hold_we_q;

   assign cpu_ready = rd_hit || st_done || resp_hit;
   assign fill_en   = resp_hit;
   assign wr_en     = resp_hit || (st_done && lk_hit);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      assign src_words[w] = resp_hit ? snp_line[w*DATA_W +: DATA_W]
                                     : rd_line[w*DATA_W +: DATA_W];
      assign wr_line[w*DATA_W +: DATA_W] =
         resp_hit                 ? snp_line[w*DATA_W +: DATA_W] :
         (lk_off == OFF_W'(w))    ? hold_data_q :
                                    rd_line[w*DATA_W +: DATA_W];
   end

   assign cpu_rdata = src_words[lk_off];

   assign bus_req   = (state_q == ST_ARB);
   assign bus_cmd   = hold_we_q ? CMD_WR : CMD_RD;
   assign bus_addr  = hold_we_q ? hold_addr_q
                                : {hold_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign bus_wdata = hold_data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         hold_addr_q <= '0;
         hold_data_q <= '0;
         hold_we_q   <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: if (cpu_req && (cpu_we || !lk_hit)) begin
               state_q     <= ST_ARB;
               hold_addr_q <= cpu_addr;
               hold_data_q <= cpu_wdata;
               hold_we_q   <= cpu_we;
            end
            ST_ARB:  if (bus_gnt) state_q <= hold_we_q ? ST_IDLE : ST_FILL;
            ST_FILL: if (resp_hit) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assert_hit_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit |=> !bus_req);

   assert_rd_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_cmd == CMD_RD) |-> (bus_addr[OFF_W-1:0] == '0));

   assert_store_on_bus_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && cpu_we && cpu_ready) |-> (bus_req && bus_gnt && bus_cmd == CMD_WR));

   assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |-> !cpu_ready);

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_cmd) &&
                                 $stable(bus_wdata)));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int LINES  = 16,
   parameter int WORDS  = 4,
   parameter int ID_W   = 3,
   parameter int MY_ID  = 0
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  cpu_req,
   input  logic                                  cpu_we,
   input  logic [ADDR_W-1:0]                     cpu_addr,
   input  logic [DATA_W-1:0]                     cpu_wdata,
   output logic                                  cpu_ready,
   output logic [DATA_W-1:0]                     cpu_rdata,
   output logic                                  bus_req,
   input  logic                                  bus_gnt,
   output logic [1:0]                            bus_cmd,
   output logic [ADDR_W-1:0]                     bus_addr,
   output logic [DATA_W-1:0]                     bus_wdata,
   output logic [ID_W-1:0]                       bus_id,
   input  logic                                  snp_valid,
   input  logic [1:0]                            snp_cmd,
   input  logic [ADDR_W-$clog2(WORDS)-1:0]       snp_laddr,
   input  logic [ID_W-1:0]                       snp_id,
   input  logic [WORDS*DATA_W-1:0]               snp_line
);
   localparam int OFF_W  = $clog2(WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam int LINE_W = WORDS * DATA_W;
   localparam int LA_W   = ADDR_W - OFF_W;

   if (WORDS < 2 || (1 << OFF_W) != WORDS) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for LINES and WORDS");
   end
   if (MY_ID < 0 || MY_ID >= (1 << ID_W)) begin : g_bad_id
      $error("MY_ID does not fit in ID_W bits");
   end

   logic [LA_W-1:0]   lk_laddr;
   logic              lk_hit, fill_en, wr_en;
   logic [LINE_W-1:0] rd_line, wr_line;
   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;

   assign lk_idx = lk_laddr[IDX_W-1:0];
   assign lk_tag = lk_laddr[LA_W-1:IDX_W];
   assign bus_id = ID_W'(MY_ID);

   wtc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .OFF_W(OFF_W), .LINE_W(LINE_W)
   ) u_ctrl (
      .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
      .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata,
      .snp_valid, .snp_cmd, .snp_laddr, .snp_line,
      .lk_laddr, .lk_hit, .rd_line, .fill_en, .wr_en, .wr_line
   );

   wtc_tag_store #(
      .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(MY_ID)
   ) u_tags (
      .clk, .rst_n,
      .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
      .snp_valid, .snp_cmd, .snp_id,
      .snp_idx(snp_laddr[IDX_W-1:0]), .snp_tag(snp_laddr[LA_W-1:IDX_W]),
      .fill_en(fill_en), .fill_idx(lk_idx), .fill_tag(lk_tag)
   );

   wtc_data_store #(
      .LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)
   ) u_data (
      .clk, .rd_idx(lk_idx), .rd_line(rd_line),
      .wr_en(wr_en), .wr_idx(lk_idx), .wr_line(wr_line)
   );
endmodule

// File: tb/test_wt_snoop_cache.sv
module test_wt_snoop_cache;
   localparam int PERIOD = 10;
   localparam int AW = 8, DW = 16, NL = 4, NW = 2, IW = 2, ME = 1;
   localparam logic [IW-1:0] MEM_ID = 2'd3, OTHER = 2'd2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cpu_req = 0, cpu_we = 0, bus_gnt = 0, snp_valid = 0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic [1:0] snp_cmd = '0;
   logic [AW-2:0] snp_laddr = '0;
   logic [IW-1:0] snp_id = '0;
   logic [NW*DW-1:0] snp_line = '0;
   logic cpu_ready, bus_req;
   logic [DW-1:0] cpu_rdata, bus_wdata;
   logic [1:0] bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [IW-1:0] bus_id;

   int n_chk = 0, n_fail = 0;
   logic [DW-1:0] mem [256];
   bit mv [NL];
   logic [4:0] mt [NL];

   always #(PERIOD/2) clk = ~clk;

   wt_snoop_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WORDS(NW), .ID_W(IW), .MY_ID(ME))
   i_wt_snoop_cache (
      .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_ready, .cpu_rdata,
      .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_id,
      .snp_valid, .snp_cmd, .snp_laddr, .snp_id, .snp_line
   );

   function automatic logic [1:0] idx_of(logic [AW-1:0] a); return a[2:1]; endfunction
   function automatic logic [4:0] tag_of(logic [AW-1:0] a); return a[7:3]; endfunction
   function automatic bit model_hit(logic [AW-1:0] a);
      return mv[idx_of(a)] && mt[idx_of(a)] == tag_of(a);
   endfunction

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h @%0t", what, act, exp, $time);
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 0; cpu_req = 0; bus_gnt = 0; snp_valid = 0;
      for (int i = 0; i < NL; i++) mv[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      #1;
      chk(!bus_req && !cpu_ready, "R1 outputs idle after reset", {bus_req, cpu_ready}, 0);
   endtask

   task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input int gdel, output logic [DW-1:0] rd, output bit srd,
                         output bit swr, output int cyc);
      bit done = 0, pend = 0, early = 0, moved = 0, seen = 0;
      int gd, rdly = 0;
      logic [AW-1:0] first_addr = '0;
      gd = (gdel < 0) ? int'($urandom % 4) : gdel;
      srd = 0; swr = 0; cyc = 0; rd = '0;
      @(negedge clk);
      cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; bus_gnt = 0; snp_valid = 0;
      while (!done && cyc < 60) begin
         #1;
         if (bus_req) begin
            if (!seen) begin first_addr = bus_addr; seen = 1; end
            else if (bus_addr !== first_addr) moved = 1;
            if (!bus_gnt && cpu_ready) early = 1;
         end
         if (bus_req && bus_gnt) begin
            if (bus_cmd == 2'd1) begin
               swr = 1;
               chk(bus_addr == a, "R5 bus write address", bus_addr, a);
               chk(bus_wdata == wd, "R5 bus write data", bus_wdata, wd);
               mem[bus_addr] = bus_wdata;
            end else begin
               srd = 1;
               chk(bus_cmd == 2'd0 && bus_addr == {a[AW-1:1], 1'b0},
                   "R3 bus read command and aligned address", {bus_cmd, bus_addr}, {2'd0, a[AW-1:1], 1'b0});
               chk(bus_id == IW'(ME), "R3 bus read carries own ID", bus_id, ME);
               pend = 1; rdly = int'($urandom % 3);
            end
         end
         if (cpu_ready) begin rd = cpu_rdata; done = 1; end
         @(negedge clk);
         bus_gnt = 0; snp_valid = 0;
         if (done) cpu_req = 0;
         else begin
            cyc++;
            if (pend) begin
               if (rdly == 0) begin
                  snp_valid = 1; snp_cmd = 2'd2; snp_id = MEM_ID; snp_laddr = a[AW-1:1];
                  snp_line = {mem[{a[AW-1:1], 1'b1}], mem[{a[AW-1:1], 1'b0}]};
                  pend = 0;
               end else rdly--;
            end else if (bus_req) begin
               if (gd == 0) bus_gnt = 1; else gd--;
            end
         end
      end
      if (!done) begin
         cpu_req = 0;
         chk(0, "R9 request never completed", cyc, 0);
      end
      chk(!early, "R9 ready held low until grant", early, 0);
      chk(!moved, "R9 bus request held steady", moved, 0);
   endtask

   task automatic do_load(input logic [AW-1:0] a, input int gdel, output bit srd, output int cyc);
      bit hit, swr;
      logic [DW-1:0] rd;
      hit = model_hit(a);
      cpu_op(0, a, '0, gdel, rd, srd, swr, cyc);
      if (hit) begin
         chk(rd == mem[a], "R2 load hit data", rd, mem[a]);
         chk(!srd && !swr && cyc == 0, "R2 hit answered at once without bus", {srd, swr, cyc[7:0]}, 0);
      end else begin
         chk(rd == mem[a], "R4 load fill data", rd, mem[a]);
         chk(srd && !swr, "R3 load miss issues bus read", {srd, swr}, 2'b10);
         mv[idx_of(a)] = 1; mt[idx_of(a)] = tag_of(a);
      end
   endtask

   task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] wd);
      bit srd, swr;
      int cyc;
      logic [DW-1:0] rd;
      cpu_op(1, a, wd, -1, rd, srd, swr, cyc);
      chk(swr && !srd, "R5 store issues exactly one bus write", {srd, swr}, 2'b01);
   endtask

   task automatic snoop(input logic [1:0] cmd, input logic [IW-1:0] id,
                        input logic [AW-1:0] a, input logic [DW-1:0] wd);
      @(negedge clk);
      snp_valid = 1; snp_cmd = cmd; snp_id = id; snp_laddr = a[AW-1:1]; snp_line = '0;
      if (cmd == 2'd1 && id != IW'(ME)) begin
         mem[a] = wd;
         if (model_hit(a)) mv[idx_of(a)] = 0;
      end
      @(negedge clk);
      snp_valid = 0;
   endtask

   initial begin
      bit srd;
      int cyc;
      void'($urandom(32'd2024));
      for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
      for (int i = 0; i < NL; i++) mv[i] = 0;
      apply_reset();

      // R1: every line starts Invalid
      for (int i = 0; i < 8; i++) begin
         do_load(AW'(i), -1, srd, cyc);
         if (i % 2 == 0) chk(srd, "R1 first load after reset misses", srd, 1);
      end
      // R2: repeat hits
      do_load(8'd3, -1, srd, cyc);
      chk(!srd && cyc == 0, "R2 directed hit", cyc, 0);
      // R6: store hit updates local copy and stays valid
      do_store(8'd4, 16'hBEEF);
      do_load(8'd4, -1, srd, cyc);
      chk(!srd, "R6 store hit keeps line valid", srd, 0);
      // R6: store miss does not allocate nor evict
      do_store(8'd20, 16'h1234);
      do_load(8'd4, -1, srd, cyc);
      chk(!srd, "R6 store miss leaves resident line", srd, 0);
      do_load(8'd20, -1, srd, cyc);
      chk(srd, "R6 store miss did not allocate", srd, 1);
      // R7: other agent writes other word of held line
      do_load(8'd6, -1, srd, cyc);
      snoop(2'd1, OTHER, 8'd7, 16'h7777);
      do_load(8'd6, -1, srd, cyc);
      chk(srd, "R7 snooped write to same line invalidates", srd, 1);
      do_load(8'd7, -1, srd, cyc);
      // R8: own ID, read snoop, other tag
      do_load(8'd10, -1, srd, cyc);
      snoop(2'd1, IW'(ME), 8'd10, 16'h0);
      snoop(2'd0, OTHER, 8'd10, 16'h0);
      snoop(2'd1, OTHER, 8'd18, 16'h5A5A);
      do_load(8'd10, -1, srd, cyc);
      chk(!srd, "R8 ignored snoops keep line valid", srd, 0);
      // R9: long grant delay
      do_load(8'd30, 6, srd, cyc);
      chk(srd && cyc >= 7, "R9 load stalls for delayed grant", cyc, 7);

      for (int n = 0; n < 800; n++) begin
         int r;
         logic [AW-1:0] a;
         r = int'($urandom % 10);
         a = AW'($urandom % 32);
         if (r < 4) do_load(a, -1, srd, cyc);
         else if (r < 7) do_store(a, DW'($urandom));
         else if (r < 9) snoop(2'd1, OTHER, a, DW'($urandom));
         else snoop(($urandom % 2) ? 2'd1 : 2'd0, ($urandom % 2) ? IW'(ME) : OTHER, a, DW'($urandom));
      end

      // R1: a later reset drops held lines
      do_load(8'd12, -1, srd, cyc);
      apply_reset();
      do_load(8'd12, -1, srd, cyc);
      chk(srd, "R1 reset invalidates held line", srd, 1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule